// File: doc/BRIEF.md
# Oversampled Bit-Clock Recovery Loop

This block pulls a bit clock out of a serial NRZ or NRZI data line that is sampled by a much faster system clock. The line is first passed through a synchronizer. Every transition, rising or falling, becomes a one-cycle pulse. These pulses put energy at the baud rate, which a plain data line does not carry in a form a loop can track.

A phase-accumulator oscillator runs at a programmable nominal rate. On each pulse, the accumulator phase is read as an error against a quarter-turn target. A proportional-plus-integral correction then pulls the oscillator's phase and trims its rate. The target is chosen so that the rising edge of the recovered clock, which is the sampling instant, lands a quarter bit after the data edges. Between transitions there is no error and no correction, so the loop free-runs. A lock flag reports whether recent edges have landed close to the target.

Top module: `cdr_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rec_clk`, `sample_stb`, `sample_bit` and `locked` are 0. The accumulator and the rate trim restart from zero.
- R2: With no transitions, the 32-bit accumulator advances by `freq_word` plus the rate trim on every clock, and `rec_clk` is its MSB. With `freq_word` = 0x1000_0000, `rec_clk` has a period of 16 clocks and is high for 8 of them.
- R3: `sample_stb` is a one-cycle pulse registered with each rising edge of `rec_clk`. `sample_bit` changes only together with `sample_stb`, and takes the synchronized data level at that point.
- R4: Both rising and falling edges of `din` are detected after a two-flop synchronizer. Take `kp_shift` = 0 and `freq_word` = 0x1000_0000, with `din` changed just before clock edge k. The accumulator is then set to 0x5000_0000 at edge k+2, whatever its earlier phase, so `rec_clk` and `sample_stb` rise at edge k+5 and not at edge k+4.
- R5: On a pulse, the phase error is the signed value (accumulator − 0x4000_0000). The accumulator's next value is accumulator + rate − (error >>> `kp_shift`), using an arithmetic shift.
- R6: On a pulse, the rate trim loses (error >>> `ki_shift`). The new rate, `freq_word` + trim, applies from the following clock.
- R7: A shift setting of 32 or more turns that term off: it adds zero correction.
- R8: In cycles without a pulse, neither the rate trim nor the lock state changes.
- R9: `locked` goes to 1 on the 16th consecutive pulse whose absolute phase error is strictly below `lock_thresh`. A threshold of 0 never counts a pulse as good.
- R10: Once locked, `locked` returns to 0 on the 4th consecutive pulse whose absolute error is at or above `lock_thresh`. Fewer than 4 such pulses leave it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Raw serial data line, asynchronous |
| freq_word | input | 32 | Nominal phase step per clock (rate = freq_word / 2^32 of clk) |
| kp_shift | input | 6 | Proportional gain as right shift; 32 or more disables |
| ki_shift | input | 6 | Integral gain as right shift; 32 or more disables |
| lock_thresh | input | 32 | Absolute phase error limit for a good edge |
| rec_clk | output | 1 | Recovered bit clock (accumulator MSB) |
| sample_stb | output | 1 | One-cycle strobe at each rising edge of rec_clk |
| sample_bit | output | 1 | Data level captured with sample_stb |
| locked | output | 1 | Lock indicator |

## Verification
A `din` change before clock edge k reaches the correction at edge k+2, after two synchronizer flops and the delay flop. From the snapped phase, the bench counts accumulator steps forward to predict the exact edge where `sample_stb` rises. It samples at the falling edge after that clock and also one cycle earlier, so a result that is late or early by one cycle shows up. The lock flag is registered on the pulse edge itself and is read three cycles after each toggle. Rate changes from the integral term are checked by counting the cycles between strobes across a full window.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

    localparam int unsigned PHASE_W_DEF   = 32;
    localparam int unsigned SHIFT_W_DEF   = 6;
    localparam int unsigned SYNC_DEF      = 2;
    localparam int unsigned GOOD_RUN_DEF  = 16;
    localparam int unsigned BAD_RUN_DEF   = 4;

    // one transition event per system clock
    typedef struct packed {
        logic pulse;   // a transition was seen on the synchronized line
        logic level;   // current synchronized line level
    } edge_evt_t;

    typedef enum logic {
        LK_HUNT = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/cdr_edge_det.sv
module cdr_edge_det
    import cdr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output edge_evt_t evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   dly_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) dly_q <= 1'b0;
        else     dly_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        evt.level = sync_q[SYNC_STAGES-1];
        evt.pulse = sync_q[SYNC_STAGES-1] ^ dly_q;
    end

endmodule

// File: rtl/cdr_nco_loop.sv
module cdr_nco_loop
    import cdr_pkg::*;
#(
    parameter int unsigned PHASE_W = PHASE_W_DEF,
    parameter int unsigned SHIFT_W = SHIFT_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  edge_evt_t          evt,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic [SHIFT_W-1:0] kp_shift,
    input  logic [SHIFT_W-1:0] ki_shift,
    output logic [PHASE_W-1:0] phase_err,
    output logic [PHASE_W-1:0] freq_trim,
    output logic               rec_clk,
    output logic               sample_stb,
    output logic               sample_bit
);

    // quarter turn: edges should land here, a quarter bit before the MSB rises
    localparam logic [PHASE_W-1:0] QUARTER = {2'b01, {(PHASE_W-2){1'b0}}};

    function automatic logic [PHASE_W-1:0] gain_term(
        input logic [PHASE_W-1:0] err,
        input logic [SHIFT_W-1:0] sh
    );
        logic signed [PHASE_W-1:0] s_err;
        s_err = signed'(err);
        if (int'(sh) >= int'(PHASE_W)) return '0;
        return PHASE_W'(s_err >>> sh);
    endfunction

    logic [PHASE_W-1:0] acc_q, acc_d;
    logic [PHASE_W-1:0] trim_q, trim_d;
    logic [PHASE_W-1:0] step;
    logic [PHASE_W-1:0] p_corr, i_corr;
    logic               msb_rise;
    logic               stb_q, bit_q;

    always_comb begin
        phase_err = acc_q - QUARTER;
        step      = freq_word + trim_q;
        p_corr    = evt.pulse ? gain_term(phase_err, kp_shift) : '0;
        i_corr    = evt.pulse ? gain_term(phase_err, ki_shift) : '0;
        acc_d     = acc_q + step - p_corr;
        trim_d    = trim_q - i_corr;
        msb_rise  = ~acc_q[PHASE_W-1] & acc_d[PHASE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            trim_q <= '0;
            stb_q  <= 1'b0;
            bit_q  <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            trim_q <= trim_d;
            stb_q  <= msb_rise;
            if (msb_rise) bit_q <= evt.level;
        end
    end

    assign freq_trim  = trim_q;
    assign rec_clk    = acc_q[PHASE_W-1];
    assign sample_stb = stb_q;
    assign sample_bit = bit_q;

endmodule

// File: rtl/cdr_lock_det.sv
module cdr_lock_det
    import cdr_pkg::*;
#(
    parameter int unsigned PHASE_W  = PHASE_W_DEF,
    parameter int unsigned GOOD_RUN = GOOD_RUN_DEF,
    parameter int unsigned BAD_RUN  = BAD_RUN_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pulse,
    input  logic [PHASE_W-1:0] phase_err,
    input  logic [PHASE_W-1:0] lock_thresh,
    output logic               locked
);

    localparam int unsigned GOOD_W = $clog2(GOOD_RUN + 1);
    localparam int unsigned BAD_W  = $clog2(BAD_RUN + 1);

    lock_state_e        state_q;
    logic [GOOD_W-1:0]  good_q;
    logic [BAD_W-1:0]   bad_q;
    logic [PHASE_W-1:0] mag;
    logic               near;

    always_comb begin
        mag  = phase_err[PHASE_W-1] ? (~phase_err + 1'b1) : phase_err;
        near = mag < lock_thresh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_HUNT;
            good_q  <= '0;
            bad_q   <= '0;
        end else if (pulse) begin
            if (near) begin
                bad_q <= '0;
                if (state_q == LK_HUNT) begin
                    if (good_q == GOOD_W'(GOOD_RUN - 1)) begin
                        state_q <= LK_HELD;
                        good_q  <= '0;
                    end else begin
                        good_q <= good_q + 1'b1;
                    end
                end
            end else begin
                good_q <= '0;
                if (state_q == LK_HELD) begin
                    if (bad_q == BAD_W'(BAD_RUN - 1)) begin
                        state_q <= LK_HUNT;
                        bad_q   <= '0;
                    end else begin
                        bad_q <= bad_q + 1'b1;
                    end
                end
            end
        end
    end

    assign locked = (state_q == LK_HELD);

endmodule

// File: rtl/cdr_top.sv
module cdr_top
    import cdr_pkg::*;
#(
    parameter int unsigned PHASE_W     = PHASE_W_DEF,
    parameter int unsigned SHIFT_W     = SHIFT_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF,
    parameter int unsigned GOOD_RUN    = GOOD_RUN_DEF,
    parameter int unsigned BAD_RUN     = BAD_RUN_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    input  logic [PHASE_W-1:0] freq_word,
    input  logic [SHIFT_W-1:0] kp_shift,
    input  logic [SHIFT_W-1:0] ki_shift,
    input  logic [PHASE_W-1:0] lock_thresh,
    output logic               rec_clk,
    output logic               sample_stb,
    output logic               sample_bit,
    output logic               locked
);

    edge_evt_t          edge_evt;
    logic [PHASE_W-1:0] phase_err;
    logic [PHASE_W-1:0] freq_trim;

    cdr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk (clk),
        .rst (rst),
        .din (din),
        .evt (edge_evt)
    );

    cdr_nco_loop #(.PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W)) u_loop (
        .clk        (clk),
        .rst        (rst),
        .evt        (edge_evt),
        .freq_word  (freq_word),
        .kp_shift   (kp_shift),
        .ki_shift   (ki_shift),
        .phase_err  (phase_err),
        .freq_trim  (freq_trim),
        .rec_clk    (rec_clk),
        .sample_stb (sample_stb),
        .sample_bit (sample_bit)
    );

    cdr_lock_det #(.PHASE_W(PHASE_W), .GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN)) u_lock (
        .clk         (clk),
        .rst         (rst),
        .pulse       (edge_evt.pulse),
        .phase_err   (phase_err),
        .lock_thresh (lock_thresh),
        .locked      (locked)
    );

endmodule

// File: rtl/cdr_checker.sv
module cdr_checker #(
    parameter int unsigned PHASE_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               edge_pulse,
    input logic [PHASE_W-1:0] freq_trim,
    input logic               rec_clk,
    input logic               sample_stb,
    input logic               sample_bit,
    input logic               locked
);

    assert_stb_at_clk_rise_R3: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (rec_clk && !$past(rec_clk)));

    assert_stb_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb);

    assert_bit_moves_with_stb_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sample_bit) |-> sample_stb);

    assert_trim_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !edge_pulse |=> $stable(freq_trim));

    assert_lock_set_on_edge_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(edge_pulse));

    assert_lock_clear_on_edge_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(edge_pulse));

endmodule

bind cdr_top cdr_checker #(.PHASE_W(PHASE_W)) u_cdr_checker (
    .clk        (clk),
    .rst        (rst),
    .edge_pulse (edge_evt.pulse),
    .freq_trim  (freq_trim),
    .rec_clk    (rec_clk),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .locked     (locked)
);

// File: tb/cdr_top_bench.sv
module cdr_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        din = 1'b0;
    logic [31:0] freq_word = 32'h1000_0000;
    logic [5:0]  kp_shift = 6'd0;
    logic [5:0]  ki_shift = 6'd32;
    logic [31:0] lock_thresh = 32'd0;
    logic        rec_clk, sample_stb, sample_bit, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cdr_top u_cdr_top (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .freq_word   (freq_word),
        .kp_shift    (kp_shift),
        .ki_shift    (ki_shift),
        .lock_thresh (lock_thresh),
        .rec_clk     (rec_clk),
        .sample_stb  (sample_stb),
        .sample_bit  (sample_bit),
        .locked      (locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // move forward n falling edges (each crossing one rising edge)
    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        din = 1'b0;
        rst = 1'b1;
        adv(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_stb;
        int n_hi;
        @(negedge clk);
        do_reset();

        // R1: outputs clear right after reset
        chk("R1 rec_clk", rec_clk, 0);
        chk("R1 sample_stb", sample_stb, 0);
        chk("R1 sample_bit", sample_bit, 0);
        chk("R1 locked", locked, 0);

        // R2/R3: free run, period 16, half high
        n_stb = 0; n_hi = 0;
        for (int i = 0; i < 160; i++) begin
            adv(1);
            n_stb += sample_stb;
            n_hi  += rec_clk;
        end
        chk("R2 rec_clk high cycles", n_hi, 80);
        chk("R3 strobe count", n_stb, 10);
        chk("R3 idle sample_bit", sample_bit, 0);

        // R4: both polarities at every phase offset, snap with kp 0
        for (int i = 0; i < 32; i++) begin
            adv(i % 16);
            din = ~din;
            adv(5);
            chk("R4 no strobe at k+4", sample_stb, 0);
            chk("R4 rec_clk low at k+4", rec_clk, 0);
            adv(1);
            chk("R4 strobe at k+5", sample_stb, 1);
            chk("R4 rec_clk high at k+5", rec_clk, 1);
            chk("R3 sampled level", sample_bit, din);
        end
        chk("R9 zero threshold never locks", locked, 0);

        // R7: integral term off, rate unchanged after many edges
        n_stb = 0;
        for (int i = 0; i < 64; i++) begin
            adv(1);
            n_stb += sample_stb;
        end
        chk("R7 rate untouched", n_stb, 4);

        // R5: half-gain proportional pull; edge at error 0x2000_0000
        din = ~din;
        adv(2);
        din = ~din;
        adv(1);
        kp_shift = 6'd1;
        adv(3);
        chk("R5 no strobe at k+5", sample_stb, 0);
        adv(1);
        chk("R5 strobe at k+6", sample_stb, 1);
        kp_shift = 6'd0;

        // R6: integral quarter gain halves the rate to period 32
        din = ~din;
        adv(2);
        din = ~din;
        adv(1);
        ki_shift = 6'd2;
        adv(7);
        chk("R6 no strobe at k+9", sample_stb, 0);
        adv(1);
        chk("R6 strobe at k+10", sample_stb, 1);
        n_stb = 0;
        for (int i = 0; i < 31; i++) begin
            adv(1);
            n_stb += sample_stb;
        end
        chk("R6 gap without strobe", n_stb, 0);
        adv(1);
        chk("R6 strobe after 32", sample_stb, 1);

        // R9: lock acquisition
        ki_shift = 6'd32;
        lock_thresh = 32'd0;
        do_reset();
        din = ~din;
        adv(3);
        lock_thresh = 32'h0100_0000;
        adv(13);
        for (int n = 1; n <= 16; n++) begin
            din = ~din;
            adv(3);
            if (n == 15) chk("R9 not locked after 15", locked, 0);
            if (n == 16) chk("R9 locked after 16", locked, 1);
            adv(13);
        end

        // R8: no edges, lock and rate hold
        n_stb = 0;
        for (int i = 0; i < 192; i++) begin
            adv(1);
            n_stb += sample_stb;
        end
        chk("R8 strobes while idle", n_stb, 12);
        chk("R8 lock held while idle", locked, 1);

        // R10: first edge on target, then four far off
        for (int i = 0; i < 5; i++) begin
            din = ~din;
            adv(3);
            if (i == 3) chk("R10 still locked after 3 bad", locked, 1);
            if (i == 4) chk("R10 unlocked after 4 bad", locked, 0);
            adv(21);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule